// File: doc/BRIEF.md
# Domain-Tagged Protection Lookaside Buffer

This block is a small, fully associative cache of memory-permission records for a protection scheme that works at word granularity. Each record belongs to one protection domain and covers one naturally aligned region whose size is a power of two, from a single 4-byte word up to the whole address space. A lookup presents a word address and a domain number. One cycle later the block returns whether a record covers that address, the 2-bit permission it grants, and the first and last word addresses of the covering region. A sidecar register can load that base and bound directly. The block performs no address translation.

Records are installed through a refill port that carries a domain, a base address, the base-2 logarithm of the region size in bytes, and a permission. A refill that repeats an existing record's domain and region rewrites that record. Any other refill takes the next slot in a rotating order. A flush port discards every record of one domain in a single cycle. Where nested regions of the same domain both cover an address, the innermost region decides the result, so a small exception can be carved out of a larger grant.

Top module: `prot_lkbuf`

## Requirements
- R1: After a synchronous reset, every slot is empty and every lookup misses. Reset also clears the response outputs.
- R2: A lookup accepted with `lk_valid` high produces `rsp_valid` high exactly one cycle later, and `rsp_valid` is low otherwise. The result reflects the contents before any refill or flush applied in the same cycle as the lookup.
- R3: A lookup hits a record only if the record is valid, its domain equals `lk_dom`, and `lk_addr` equals the record base in every bit at or above the region's size exponent. Lower bits are ignored.
- R4: The refill size exponent is clamped to the range 2 to 32. When a refill is stored, its base bits below the exponent are forced to zero.
- R5: When several records hit, the one with the smallest region wins. Among records of equal size, the lowest slot index wins.
- R6: On a hit, the block returns the permission, the region base, and the bound, which is base + 2^size - 4. The permission codes are 0 none, 1 read-only, 2 read-write and 3 execute-read. On a miss, or when no lookup was made, `rsp_hit`, `rsp_perm`, `rsp_base` and `rsp_bound` are all zero.
- R7: A refill whose domain, normalized base and size equal those of a valid record overwrites that record in place and does not advance the replacement pointer.
- R8: Every other refill is written to the slot named by a pointer. The pointer starts at slot 0, advances by one per such refill, wraps after the last slot, and ignores whether slots are valid.
- R9: A flush invalidates every record of `fl_dom` in one cycle and leaves other domains untouched. A refill in the same cycle is applied after the flush, so the record it writes is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_dom | input | 8 | Lookup domain |
| rf_valid | input | 1 | Refill request |
| rf_base | input | 32 | Refill region base |
| rf_lg | input | 6 | Refill region size exponent (bytes) |
| rf_perm | input | 2 | Refill permission code |
| rf_dom | input | 8 | Refill domain |
| fl_valid | input | 1 | Flush request |
| fl_dom | input | 8 | Domain to flush |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | A record covered the address |
| rsp_perm | output | 2 | Granted permission |
| rsp_base | output | 32 | First word of covering region |
| rsp_bound | output | 32 | Last word of covering region |

## Verification
Slot state can only be seen through lookups, so any fault in storage, the pointer, or the flush logic appears one cycle after the first lookup that touches the affected slot. Depending on the fault, it shows as a hit that should miss, a miss that should hit, the wrong permission, or the wrong base and bound. A fault in the replacement pointer or in overwrite detection stays hidden until the pointer wraps and evicts a record that should have survived. The bench therefore fills the whole buffer and probes both the evicted record and the surviving ones. A duplicate record left behind by a broken overwrite is exposed immediately, because the lowest-index tie rule returns the stale permission.

// File: rtl/plb_pkg.sv
package plb_pkg;

    localparam int PA_W        = 32;
    localparam int DOM_W       = 8;
    localparam int LG_W        = 6;
    localparam int MIN_LG      = 2;
    localparam int DEF_ENTRIES = 60;

    typedef logic [PA_W-1:0]  addr_t;
    typedef logic [DOM_W-1:0] dom_t;
    typedef logic [LG_W-1:0]  lg_t;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_RX   = 2'd3
    } perm_e;

    // mask holds ones at every address bit that takes part in the compare
    typedef struct packed {
        logic  valid;
        dom_t  dom;
        addr_t base;
        addr_t mask;
        perm_e perm;
    } plb_entry_t;

    typedef struct packed {
        dom_t  dom;
        addr_t base;
        addr_t mask;
        perm_e perm;
    } refill_t;

    function automatic lg_t clamp_lg(lg_t lg);
        if (lg < lg_t'(MIN_LG)) return lg_t'(MIN_LG);
        if (lg > lg_t'(PA_W))   return lg_t'(PA_W);
        return lg;
    endfunction

    function automatic addr_t region_mask(lg_t lg);
        addr_t m;
        for (int i = 0; i < PA_W; i++) m[i] = (i >= int'(lg));
        return m;
    endfunction

    function automatic addr_t region_bound(addr_t base, addr_t mask);
        return (base | ~mask) & ~addr_t'(3);
    endfunction

endpackage

// File: rtl/plb_slot.sv
module plb_slot
    import plb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  refill_t    wr,
    input  logic       fl_en,
    input  dom_t       fl_dom,
    input  addr_t      lk_addr,
    input  dom_t       lk_dom,
    output plb_entry_t ent,
    output logic       hit,
    output logic       same
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (wr_en) begin
            ent.valid <= 1'b1;
            ent.dom   <= wr.dom;
            ent.base  <= wr.base;
            ent.mask  <= wr.mask;
            ent.perm  <= wr.perm;
        end else if (fl_en && ent.valid && ent.dom == fl_dom) begin
            ent.valid <= 1'b0;
        end
    end

    always_comb begin
        hit  = ent.valid && (ent.dom == lk_dom)
               && (((lk_addr ^ ent.base) & ent.mask) == '0);
        same = ent.valid && (ent.dom == wr.dom)
               && (ent.mask == wr.mask) && (ent.base == wr.base);
    end

    // R9: a flush of this slot's domain with no write drops the slot
    p_flush_drops_r9: assert property (@(posedge clk) disable iff (rst)
        (fl_en && !wr_en && ent.valid && ent.dom == fl_dom) |=> !ent.valid);

    // R7: a write always lands with the offered contents
    p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent.valid && ent.base == $past(wr.base) && ent.perm == $past(wr.perm)));

    // R4: stored bases stay aligned to their region
    p_base_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        ent.valid |-> ((ent.base & ~ent.mask) == '0));

endmodule

// File: rtl/plb_pick.sv
module plb_pick
    import plb_pkg::*;
#(
    parameter int NUM = DEF_ENTRIES
) (
    input  logic [NUM-1:0] hit_vec,
    input  addr_t          masks [NUM],
    output logic [NUM-1:0] win_oh,
    output logic           any_hit
);

    addr_t best;

    // a larger mask value means more compared bits, hence a smaller region
    always_comb begin
        win_oh  = '0;
        any_hit = 1'b0;
        best    = '0;
        for (int i = 0; i < NUM; i++) begin
            if (hit_vec[i] && (!any_hit || masks[i] > best)) begin
                win_oh    = '0;
                win_oh[i] = 1'b1;
                best      = masks[i];
                any_hit   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/plb_rr.sv
module plb_rr
    import plb_pkg::*;
#(
    parameter int NUM = DEF_ENTRIES,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IDX_W'(NUM-1)) ? '0 : ptr + 1'b1;
    end

    p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst)
        ptr <= IDX_W'(NUM-1));

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr));

endmodule

// File: rtl/prot_lkbuf.sv
module prot_lkbuf
    import plb_pkg::*;
#(
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PA_W-1:0] lk_addr,
    input  logic [DOM_W-1:0] lk_dom,
    input  logic            rf_valid,
    input  logic [PA_W-1:0] rf_base,
    input  logic [LG_W-1:0] rf_lg,
    input  logic [1:0]      rf_perm,
    input  logic [DOM_W-1:0] rf_dom,
    input  logic            fl_valid,
    input  logic [DOM_W-1:0] fl_dom,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [1:0]      rsp_perm,
    output logic [PA_W-1:0] rsp_base,
    output logic [PA_W-1:0] rsp_bound
);

    refill_t                rf_n;
    plb_entry_t             ents    [NUM_ENTRIES];
    addr_t                  masks   [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [NUM_ENTRIES-1:0] same_vec;
    logic [NUM_ENTRIES-1:0] exact_oh;
    logic [NUM_ENTRIES-1:0] wr_vec;
    logic [NUM_ENTRIES-1:0] win_oh;
    logic                   any_hit;
    logic                   any_exact;
    logic [IDX_W-1:0]       ptr;
    plb_entry_t             sel;

    // normalise the offered region before it reaches any slot
    always_comb begin
        rf_n.mask = region_mask(clamp_lg(rf_lg));
        rf_n.base = rf_base & rf_n.mask;
        rf_n.dom  = rf_dom;
        rf_n.perm = perm_e'(rf_perm);
    end

    always_comb begin
        exact_oh = '0;
        for (int i = 0; i < NUM_ENTRIES; i++)
            if (same_vec[i] && exact_oh == '0) exact_oh[i] = 1'b1;
    end

    assign any_exact = |same_vec;

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
            assign wr_vec[g] = rf_valid
                && (any_exact ? exact_oh[g] : (ptr == IDX_W'(g)));
            assign masks[g] = ents[g].mask;

            plb_slot i_slot (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_vec[g]),
                .wr      (rf_n),
                .fl_en   (fl_valid),
                .fl_dom  (fl_dom),
                .lk_addr (lk_addr),
                .lk_dom  (lk_dom),
                .ent     (ents[g]),
                .hit     (hit_vec[g]),
                .same    (same_vec[g])
            );
        end
    endgenerate

    plb_rr #(.NUM(NUM_ENTRIES)) i_rr (
        .clk (clk),
        .rst (rst),
        .adv (rf_valid && !any_exact),
        .ptr (ptr)
    );

    plb_pick #(.NUM(NUM_ENTRIES)) i_pick (
        .hit_vec (hit_vec),
        .masks   (masks),
        .win_oh  (win_oh),
        .any_hit (any_hit)
    );

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_ENTRIES; i++)
            if (win_oh[i]) sel = plb_entry_t'(sel | ents[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_perm  <= '0;
            rsp_base  <= '0;
            rsp_bound <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid && any_hit) begin
                rsp_hit   <= 1'b1;
                rsp_perm  <= sel.perm;
                rsp_base  <= sel.base;
                rsp_bound <= region_bound(sel.base, sel.mask);
            end else begin
                rsp_hit   <= 1'b0;
                rsp_perm  <= '0;
                rsp_base  <= '0;
                rsp_bound <= '0;
            end
        end
    end

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_perm == '0 && rsp_base == '0 && rsp_bound == '0));

    p_bound_order_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_bound >= rsp_base && rsp_bound[1:0] == 2'b00));

    p_single_winner_r5: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $onehot0(win_oh));

    p_exact_unique_r7: assert property (@(posedge clk) disable iff (rst)
        rf_valid |-> $onehot0(same_vec));

endmodule

// File: tb/test_prot_lkbuf.sv
module test_prot_lkbuf;

    localparam int NE = 60;

    typedef struct packed {
        logic [1:0]  op;     // 0 lookup, 1 refill
        logic [7:0]  dom;
        logic [31:0] addr;
        logic [5:0]  lg;
        logic [1:0]  perm;   // refill permission or expected permission
        logic        hit;
        logic [31:0] base;
        logic [31:0] bound;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd1, 32'h0000_1abc, 6'd0,  2'd0, 1'b0, 32'h0,         32'h0,         4'd1}, // R1 empty
        '{2'd1, 8'd1, 32'h0000_1000, 6'd12, 2'd2, 1'b0, 32'h0,         32'h0,         4'd0},
        '{2'd0, 8'd1, 32'h0000_1abc, 6'd0,  2'd2, 1'b1, 32'h0000_1000, 32'h0000_1ffc, 4'd6}, // R6
        '{2'd0, 8'd2, 32'h0000_1abc, 6'd0,  2'd0, 1'b0, 32'h0,         32'h0,         4'd3}, // R3 domain
        '{2'd0, 8'd1, 32'h0000_2000, 6'd0,  2'd0, 1'b0, 32'h0,         32'h0,         4'd3}, // R3 above
        '{2'd0, 8'd1, 32'h0000_0ffc, 6'd0,  2'd0, 1'b0, 32'h0,         32'h0,         4'd3}, // R3 below
        '{2'd1, 8'd1, 32'h0000_1100, 6'd8,  2'd1, 1'b0, 32'h0,         32'h0,         4'd0},
        '{2'd0, 8'd1, 32'h0000_1140, 6'd0,  2'd1, 1'b1, 32'h0000_1100, 32'h0000_11fc, 4'd5}, // R5 inner
        '{2'd0, 8'd1, 32'h0000_1200, 6'd0,  2'd2, 1'b1, 32'h0000_1000, 32'h0000_1ffc, 4'd5}, // R5 outer
        '{2'd1, 8'd1, 32'h0000_30f4, 6'd4,  2'd3, 1'b0, 32'h0,         32'h0,         4'd0},
        '{2'd0, 8'd1, 32'h0000_30f8, 6'd0,  2'd3, 1'b1, 32'h0000_30f0, 32'h0000_30fc, 4'd4}, // R4 align
        '{2'd0, 8'd1, 32'h0000_3100, 6'd0,  2'd0, 1'b0, 32'h0,         32'h0,         4'd4},
        '{2'd1, 8'd1, 32'h0000_1000, 6'd12, 2'd1, 1'b0, 32'h0,         32'h0,         4'd0},
        '{2'd0, 8'd1, 32'h0000_1abc, 6'd0,  2'd1, 1'b1, 32'h0000_1000, 32'h0000_1ffc, 4'd7}, // R7 in place
        '{2'd0, 8'd1, 32'h0000_1140, 6'd0,  2'd1, 1'b1, 32'h0000_1100, 32'h0000_11fc, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [7:0]  lk_dom = '0;
    logic        rf_valid = 1'b0;
    logic [31:0] rf_base = '0;
    logic [5:0]  rf_lg = '0;
    logic [1:0]  rf_perm = '0;
    logic [7:0]  rf_dom = '0;
    logic        fl_valid = 1'b0;
    logic [7:0]  fl_dom = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_perm;
    logic [31:0] rsp_base, rsp_bound;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    prot_lkbuf #(.NUM_ENTRIES(NE)) i_prot_lkbuf (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_dom(lk_dom),
        .rf_valid(rf_valid), .rf_base(rf_base), .rf_lg(rf_lg),
        .rf_perm(rf_perm), .rf_dom(rf_dom),
        .fl_valid(fl_valid), .fl_dom(fl_dom),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_perm(rsp_perm),
        .rsp_base(rsp_base), .rsp_bound(rsp_bound)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check_rsp(string req, logic ev, logic eh, logic [1:0] ep,
                             logic [31:0] eb, logic [31:0] ebd);
        checks++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_perm !== ep
            || rsp_base !== eb || rsp_bound !== ebd) begin
            fails++;
            $display("FAIL %s: actual v=%0b h=%0b p=%0d base=%h bound=%h expected v=%0b h=%0b p=%0d base=%h bound=%h",
                     req, rsp_valid, rsp_hit, rsp_perm, rsp_base, rsp_bound,
                     ev, eh, ep, eb, ebd);
        end
    endtask

    task automatic refill(logic [7:0] d, logic [31:0] b, logic [5:0] lg, logic [1:0] p);
        @(negedge clk);
        rf_valid = 1'b1; rf_dom = d; rf_base = b; rf_lg = lg; rf_perm = p;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic flush(logic [7:0] d);
        @(negedge clk);
        fl_valid = 1'b1; fl_dom = d;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic lookup(string req, logic [7:0] d, logic [31:0] a, logic eh,
                          logic [1:0] ep, logic [31:0] eb, logic [31:0] ebd);
        @(negedge clk);
        lk_valid = 1'b1; lk_dom = d; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check_rsp(req, 1'b1, eh, ep, eb, ebd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs idle right after reset
        check_rsp("R1", 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == 2'd1)
                refill(VECS[i].dom, VECS[i].addr, VECS[i].lg, VECS[i].perm);
            else
                lookup($sformatf("R%0d", VECS[i].req), VECS[i].dom, VECS[i].addr,
                       VECS[i].hit, VECS[i].perm, VECS[i].base, VECS[i].bound);
        end

        // R8: pointer is at slot 3; fill slots 3..NE-1 with domain 3
        for (int i = 0; i < NE - 3; i++)
            refill(8'd3, 32'h0010_0000 + i * 256, 6'd8, 2'(i % 4));
        lookup("R8", 8'd1, 32'h0000_1abc, 1'b1, 2'd1, 32'h0000_1000, 32'h0000_1ffc);
        refill(8'd3, 32'h0020_0000, 6'd8, 2'd2);   // wraps onto slot 0
        lookup("R8", 8'd1, 32'h0000_1abc, 1'b0, 2'd0, 32'h0, 32'h0);
        lookup("R8", 8'd1, 32'h0000_1140, 1'b1, 2'd1, 32'h0000_1100, 32'h0000_11fc);
        lookup("R8", 8'd3, 32'h0020_0010, 1'b1, 2'd2, 32'h0020_0000, 32'h0020_00fc);
        for (int i = 0; i < NE - 3; i++)
            lookup("R8", 8'd3, 32'h0010_0004 + i * 256, 1'b1, 2'(i % 4),
                   32'h0010_0000 + i * 256, 32'h0010_00fc + i * 256);

        // R4: oversize exponent covers everything (slot 1)
        refill(8'd6, 32'h1234_5678, 6'd63, 2'd3);
        lookup("R4", 8'd6, 32'hdead_beec, 1'b1, 2'd3, 32'h0, 32'hffff_fffc);
        // R4: undersize exponent becomes one word (slot 2)
        refill(8'd7, 32'h0000_4006, 6'd0, 2'd2);
        lookup("R4", 8'd7, 32'h0000_4004, 1'b1, 2'd2, 32'h0000_4004, 32'h0000_4004);
        lookup("R4", 8'd7, 32'h0000_4008, 1'b0, 2'd0, 32'h0, 32'h0);

        // R2: lookup in the same cycle as the refill sees old contents (slot 3)
        @(negedge clk);
        rf_valid = 1'b1; rf_dom = 8'd5; rf_base = 32'h0000_8000; rf_lg = 6'd12; rf_perm = 2'd1;
        lk_valid = 1'b1; lk_dom = 8'd5; lk_addr = 32'h0000_8010;
        @(negedge clk);
        rf_valid = 1'b0; lk_valid = 1'b0;
        check_rsp("R2", 1'b1, 1'b0, 2'd0, 32'h0, 32'h0);
        @(negedge clk);
        check_rsp("R2", 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
        lookup("R2", 8'd5, 32'h0000_8010, 1'b1, 2'd1, 32'h0000_8000, 32'h0000_8ffc);

        // R9: flush one domain, others stay
        flush(8'd3);
        lookup("R9", 8'd3, 32'h0010_0a04, 1'b0, 2'd0, 32'h0, 32'h0);
        lookup("R9", 8'd3, 32'h0020_0010, 1'b0, 2'd0, 32'h0, 32'h0);
        lookup("R9", 8'd5, 32'h0000_8010, 1'b1, 2'd1, 32'h0000_8000, 32'h0000_8ffc);
        lookup("R9", 8'd6, 32'h0000_0000, 1'b1, 2'd3, 32'h0, 32'hffff_fffc);

        // R9: flush and refill of the same domain together
        @(negedge clk);
        fl_valid = 1'b1; fl_dom = 8'd5;
        rf_valid = 1'b1; rf_dom = 8'd5; rf_base = 32'h0000_9000; rf_lg = 6'd12; rf_perm = 2'd2;
        @(negedge clk);
        fl_valid = 1'b0; rf_valid = 1'b0;
        lookup("R9", 8'd5, 32'h0000_9abc, 1'b1, 2'd2, 32'h0000_9000, 32'h0000_9ffc);
        lookup("R9", 8'd5, 32'h0000_8010, 1'b0, 2'd0, 32'h0, 32'h0);

        // R1: reset in mid-run empties all slots
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_rsp("R1", 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
        lookup("R1", 8'd5, 32'h0000_9abc, 1'b0, 2'd0, 32'h0, 32'h0);
        lookup("R1", 8'd6, 32'h0000_0000, 1'b0, 2'd0, 32'h0, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule